// File: doc/BRIEF.md
# Fractional Baud Tick Generator with Serial Mode Register

This block produces the oversampling tick that paces an asynchronous serial receiver and transmitter. Software loads a 16-bit step value. Every system clock, the block adds that step into a 16-bit running sum. Each carry out of the sum is a baud pulse, so the average baud pulse rate is `f_clk * step / 65536`, and the step can be tuned in fine increments. A final divider turns these pulses, or the raw system clock, into the tick that the shift logic uses. The divide ratio depends on the serial mode and on a rate-select bit.

The block also holds the mode register of the serial port. This register has three live bits: a framing-error-detect select, the rate select and the serial interrupt enable. The block owns bit 7 of the serial control register. When framing-error detection is off, bit 7 is the upper mode-select bit. When detection is on, bit 7 is a sticky framing-error flag. The receive and transmit complete flags come from outside, and the block merges them into one registered interrupt request. The shift registers themselves are not part of the block.

Top module: `uart_baud_phase_gen`

## Requirements
- R1: After reset, `phase_o` is 0000h, `mode_rdata_o` is 00h, `ctl7_rdata_o`, `baud_o`, `tick_o` and `irq_o` are 0, the running sum is 0 and the divider count is 0.
- R2: A cycle with `phase_we_i` high loads `phase_wdata_i` into the 16-bit step register, and `phase_o` shows the new value from the next cycle.
- R3: `mode_we_i` loads the mode register. Bit 0 is the framing-error-detect select, bit 1 is the rate select and bit 2 is the interrupt enable. Bits 7 to 3 always read 0.
- R4: Each clock adds the step into a 16-bit sum modulo 65536. When that addition carries out, `baud_o` is high for the following cycle.
- R5: While the step is 0000h, `baud_o` stays low, and in modes 1 and 3 `tick_o` stays low.
- R6: The serial mode is {upper mode bit, `sm1_i`}. In modes 1 and 3 the divider advances once per cycle in which `baud_o` is high. It produces a one-cycle `tick_o` in the cycle after it advances from count ratio-1, where the ratio is 16 with the rate select at 1 and 64 with it at 0. The count wraps to 0 when it is at or above ratio-1.
- R7: In mode 2 the divider advances every clock, with a ratio of 32 when the rate select is 1 and 64 when it is 0. Wrapping and tick timing follow R6.
- R8: In mode 0 the divider count is held at 0 and `tick_o` stays low.
- R9: With framing-error detect at 0, a write through `ctl7_we_i` sets the upper mode bit, and `ctl7_rdata_o` returns that bit.
- R10: With framing-error detect at 1, a write through `ctl7_we_i` goes to the framing-error flag and leaves the upper mode bit unchanged. `ctl7_rdata_o` returns the flag.
- R11: The framing-error flag is set by a `fe_set_i` pulse and keeps its value until a control write with detect at 1 changes it. If a set pulse and a write of 0 arrive in the same cycle, the flag ends up set.
- R12: `irq_o` is high one cycle after a cycle in which the interrupt enable is 1 and `ri_i` or `ti_i` is high. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_we_i | input | 1 | Step register write strobe |
| phase_wdata_i | input | 16 | Step register write value |
| phase_o | output | 16 | Step register read value |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 8 | Mode register write value |
| mode_rdata_o | output | 8 | Mode register read value |
| ctl7_we_i | input | 1 | Serial control bit 7 write strobe |
| ctl7_wdata_i | input | 1 | Serial control bit 7 write value |
| ctl7_rdata_o | output | 1 | Serial control bit 7 read value (mode bit or error flag) |
| sm1_i | input | 1 | Lower serial mode bit from the control register |
| fe_set_i | input | 1 | Framing error pulse from the receiver |
| ri_i | input | 1 | Receive complete flag |
| ti_i | input | 1 | Transmit complete flag |
| baud_o | output | 1 | Baud pulse from the sum carry |
| tick_o | output | 1 | Divided oversampling tick |
| irq_o | output | 1 | Serial interrupt request |

## Verification
The properties assume that `fe_set_i`, `ri_i`, `ti_i` and `sm1_i` are synchronous to `clk_i` and held stable around each rising edge. They also assume that the control-bit write strobe lasts exactly the cycles in which the write is meant to take effect. The bench drives every input only on the falling edge, so each value is settled one half period before the edge that samples it. The bench never changes the lower mode bit mid-cycle. Mode switches and step changes still happen at arbitrary divider counts, and the same stimulus feeds a behavioural reference model. This means the at-or-above wrap rule is exercised rather than assumed away.

// File: rtl/ubg_pkg.sv
package ubg_pkg;

    typedef enum logic [1:0] {
        SER_SYNC   = 2'd0,
        SER_ASYNC1 = 2'd1,
        SER_FIXED  = 2'd2,
        SER_ASYNC3 = 2'd3
    } ser_mode_e;

    localparam int MODE_REG_W = 8;
    localparam int BIT_FEDET  = 0;
    localparam int BIT_RATE   = 1;
    localparam int BIT_IRQEN  = 2;

    typedef struct packed {
        logic upper_mode;
        logic fedet;
        logic rate;
        logic irq_en;
        logic fe_flag;
        logic irq;
    } ctl_state_t;

endpackage

// File: rtl/ubg_phase_acc.sv
module ubg_phase_acc #(
    parameter int PHASE_W = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               we_i,
    input  logic [PHASE_W-1:0] wdata_i,
    output logic [PHASE_W-1:0] step_o,
    output logic               pulse_o
);

    typedef struct packed {
        logic [PHASE_W-1:0] step;
        logic [PHASE_W-1:0] sum;
        logic               pulse;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [PHASE_W:0] wide_sum;

    always_comb begin
        st_d     = st_q;
        wide_sum = {1'b0, st_q.sum} + {1'b0, st_q.step};
        st_d.sum   = wide_sum[PHASE_W-1:0];
        st_d.pulse = wide_sum[PHASE_W];
        if (we_i) begin
            st_d.step = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign step_o  = st_q.step;
    assign pulse_o = st_q.pulse;

endmodule

// File: rtl/ubg_ratio_div.sv
module ubg_ratio_div
    import ubg_pkg::*;
#(
    parameter int RATIO_ASYNC_FAST = 16,
    parameter int RATIO_FIXED_FAST = 32,
    parameter int RATIO_SLOW       = 64
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  ser_mode_e mode_i,
    input  logic      rate_i,
    input  logic      pulse_i,
    output logic      tick_o
);

    localparam int CNT_W = $clog2(RATIO_SLOW);
    localparam logic [CNT_W-1:0] LAST_ASYNC_FAST = CNT_W'(RATIO_ASYNC_FAST - 1);
    localparam logic [CNT_W-1:0] LAST_FIXED_FAST = CNT_W'(RATIO_FIXED_FAST - 1);
    localparam logic [CNT_W-1:0] LAST_SLOW       = CNT_W'(RATIO_SLOW - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } div_state_t;

    div_state_t       st_d, st_q;
    logic             advance;
    logic [CNT_W-1:0] last;

    always_comb begin
        case (mode_i)
            SER_FIXED:  advance = 1'b1;
            SER_ASYNC1,
            SER_ASYNC3: advance = pulse_i;
            default:    advance = 1'b0;
        endcase
        if (mode_i == SER_FIXED) begin
            last = rate_i ? LAST_FIXED_FAST : LAST_SLOW;
        end else begin
            last = rate_i ? LAST_ASYNC_FAST : LAST_SLOW;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (mode_i == SER_SYNC) begin
            st_d.cnt = '0;
        end else if (advance) begin
            if (st_q.cnt >= last) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;

endmodule

// File: rtl/ubg_ctl_regs.sv
module ubg_ctl_regs
    import ubg_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  mode_we_i,
    input  logic [MODE_REG_W-1:0] mode_wdata_i,
    input  logic                  ctl7_we_i,
    input  logic                  ctl7_wdata_i,
    input  logic                  sm1_i,
    input  logic                  fe_set_i,
    input  logic                  ri_i,
    input  logic                  ti_i,
    output logic [MODE_REG_W-1:0] mode_rdata_o,
    output logic                  ctl7_rdata_o,
    output ser_mode_e             ser_mode_o,
    output logic                  rate_o,
    output logic                  fedet_o,
    output logic                  fe_flag_o,
    output logic                  irq_o
);

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mode_we_i) begin
            st_d.fedet  = mode_wdata_i[BIT_FEDET];
            st_d.rate   = mode_wdata_i[BIT_RATE];
            st_d.irq_en = mode_wdata_i[BIT_IRQEN];
        end
        if (ctl7_we_i && !st_q.fedet) begin
            st_d.upper_mode = ctl7_wdata_i;
        end
        if (fe_set_i) begin
            st_d.fe_flag = 1'b1;
        end else if (ctl7_we_i && st_q.fedet) begin
            st_d.fe_flag = ctl7_wdata_i;
        end
        st_d.irq = st_q.irq_en && (ri_i || ti_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        mode_rdata_o            = '0;
        mode_rdata_o[BIT_FEDET] = st_q.fedet;
        mode_rdata_o[BIT_RATE]  = st_q.rate;
        mode_rdata_o[BIT_IRQEN] = st_q.irq_en;
    end

    assign ctl7_rdata_o = st_q.fedet ? st_q.fe_flag : st_q.upper_mode;
    assign ser_mode_o   = ser_mode_e'({st_q.upper_mode, sm1_i});
    assign rate_o       = st_q.rate;
    assign fedet_o      = st_q.fedet;
    assign fe_flag_o    = st_q.fe_flag;
    assign irq_o        = st_q.irq;

endmodule

// File: rtl/uart_baud_phase_gen.sv
module uart_baud_phase_gen
    import ubg_pkg::*;
#(
    parameter int PHASE_W          = 16,
    parameter int RATIO_ASYNC_FAST = 16,
    parameter int RATIO_FIXED_FAST = 32,
    parameter int RATIO_SLOW       = 64
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  phase_we_i,
    input  logic [PHASE_W-1:0]    phase_wdata_i,
    output logic [PHASE_W-1:0]    phase_o,
    input  logic                  mode_we_i,
    input  logic [MODE_REG_W-1:0] mode_wdata_i,
    output logic [MODE_REG_W-1:0] mode_rdata_o,
    input  logic                  ctl7_we_i,
    input  logic                  ctl7_wdata_i,
    output logic                  ctl7_rdata_o,
    input  logic                  sm1_i,
    input  logic                  fe_set_i,
    input  logic                  ri_i,
    input  logic                  ti_i,
    output logic                  baud_o,
    output logic                  tick_o,
    output logic                  irq_o
);

    ser_mode_e ser_mode;
    logic      rate_sel;
    logic      fedet;
    logic      fe_flag;

    ubg_phase_acc #(
        .PHASE_W (PHASE_W)
    ) acc_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (phase_we_i),
        .wdata_i (phase_wdata_i),
        .step_o  (phase_o),
        .pulse_o (baud_o)
    );

    ubg_ctl_regs regs_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .mode_we_i    (mode_we_i),
        .mode_wdata_i (mode_wdata_i),
        .ctl7_we_i    (ctl7_we_i),
        .ctl7_wdata_i (ctl7_wdata_i),
        .sm1_i        (sm1_i),
        .fe_set_i     (fe_set_i),
        .ri_i         (ri_i),
        .ti_i         (ti_i),
        .mode_rdata_o (mode_rdata_o),
        .ctl7_rdata_o (ctl7_rdata_o),
        .ser_mode_o   (ser_mode),
        .rate_o       (rate_sel),
        .fedet_o      (fedet),
        .fe_flag_o    (fe_flag),
        .irq_o        (irq_o)
    );

    ubg_ratio_div #(
        .RATIO_ASYNC_FAST (RATIO_ASYNC_FAST),
        .RATIO_FIXED_FAST (RATIO_FIXED_FAST),
        .RATIO_SLOW       (RATIO_SLOW)
    ) div_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .mode_i  (ser_mode),
        .rate_i  (rate_sel),
        .pulse_i (baud_o),
        .tick_o  (tick_o)
    );

endmodule

// File: rtl/ubg_checker.sv
module ubg_checker #(
    parameter int PHASE_W = 16
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [PHASE_W-1:0] phase_o,
    input logic [7:0]         mode_rdata_o,
    input logic               baud_o,
    input logic               tick_o,
    input logic               irq_o,
    input logic [1:0]         mode_bits,
    input logic               fedet,
    input logic               fe_flag,
    input logic               fe_set_i,
    input logic               ctl7_we_i,
    input logic               ctl7_wdata_i,
    input logic               ri_i,
    input logic               ti_i
);

    assert_rsvd_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_rdata_o[7:3] == 5'd0);

    assert_zero_step_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(phase_o) == '0) |-> !baud_o);

    assert_sync_mode_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> ($past(mode_bits) != 2'd0));

    assert_async_tick_after_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && $past(mode_bits[0])) |-> $past(baud_o));

    assert_fe_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(fe_flag) && !$past(ctl7_we_i && fedet && !ctl7_wdata_i)) |-> fe_flag);

    assert_fe_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(fe_set_i) |-> fe_flag);

    assert_irq_gated_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(mode_rdata_o[2]) |-> !irq_o);

    assert_irq_raised_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(mode_rdata_o[2] && (ri_i || ti_i)) |-> irq_o);

endmodule

bind uart_baud_phase_gen ubg_checker #(
    .PHASE_W (PHASE_W)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .phase_o      (phase_o),
    .mode_rdata_o (mode_rdata_o),
    .baud_o       (baud_o),
    .tick_o       (tick_o),
    .irq_o        (irq_o),
    .mode_bits    (ser_mode),
    .fedet        (fedet),
    .fe_flag      (fe_flag),
    .fe_set_i     (fe_set_i),
    .ctl7_we_i    (ctl7_we_i),
    .ctl7_wdata_i (ctl7_wdata_i),
    .ri_i         (ri_i),
    .ti_i         (ti_i)
);

// File: tb/uart_baud_phase_gen_tb_top.sv
module uart_baud_phase_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_we = 1'b0;
    logic [15:0] phase_wdata = '0;
    logic [15:0] phase_rd;
    logic        mode_we = 1'b0;
    logic [7:0]  mode_wdata = '0;
    logic [7:0]  mode_rd;
    logic        ctl7_we = 1'b0;
    logic        ctl7_wdata = 1'b0;
    logic        ctl7_rd;
    logic        sm1 = 1'b0;
    logic        fe_set = 1'b0;
    logic        ri = 1'b0;
    logic        ti = 1'b0;
    logic        baud;
    logic        tick;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_en = 1'b0;
    int tick_seen = 0;
    int baud_seen = 0;

    always #4 clk = ~clk;

    uart_baud_phase_gen dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .phase_we_i    (phase_we),
        .phase_wdata_i (phase_wdata),
        .phase_o       (phase_rd),
        .mode_we_i     (mode_we),
        .mode_wdata_i  (mode_wdata),
        .mode_rdata_o  (mode_rd),
        .ctl7_we_i     (ctl7_we),
        .ctl7_wdata_i  (ctl7_wdata),
        .ctl7_rdata_o  (ctl7_rd),
        .sm1_i         (sm1),
        .fe_set_i      (fe_set),
        .ri_i          (ri),
        .ti_i          (ti),
        .baud_o        (baud),
        .tick_o        (tick),
        .irq_o         (irq)
    );

    // behavioural reference model
    int m_step, m_sum, m_cnt;
    bit m_baud, m_tick, m_irq, m_upper, m_fedet, m_rate, m_irqen, m_fe;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_step = 0; m_sum = 0; m_cnt = 0;
            m_baud = 0; m_tick = 0; m_irq = 0;
            m_upper = 0; m_fedet = 0; m_rate = 0; m_irqen = 0; m_fe = 0;
        end else begin
            int total, mode, ratio, n_cnt;
            bit n_tick, adv, n_fe, n_upper;
            total = m_sum + m_step;
            mode  = (m_upper ? 2 : 0) + (sm1 ? 1 : 0);
            n_cnt = m_cnt;
            n_tick = 0;
            if (mode == 0) begin
                n_cnt = 0;
            end else begin
                adv   = (mode == 2) ? 1'b1 : m_baud;
                ratio = (mode == 2) ? (m_rate ? 32 : 64) : (m_rate ? 16 : 64);
                if (adv) begin
                    if (m_cnt >= ratio - 1) begin
                        n_cnt = 0; n_tick = 1;
                    end else begin
                        n_cnt = m_cnt + 1;
                    end
                end
            end
            n_upper = m_upper;
            if (ctl7_we && !m_fedet) n_upper = ctl7_wdata;
            n_fe = m_fe;
            if (fe_set) n_fe = 1;
            else if (ctl7_we && m_fedet) n_fe = ctl7_wdata;
            m_irq   = m_irqen && (ri || ti);
            m_baud  = total > 65535;
            m_sum   = total % 65536;
            m_cnt   = n_cnt;
            m_tick  = n_tick;
            m_upper = n_upper;
            m_fe    = n_fe;
            if (phase_we) m_step = phase_wdata;
            if (mode_we) begin
                m_fedet = mode_wdata[0];
                m_rate  = mode_wdata[1];
                m_irqen = mode_wdata[2];
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (tick) tick_seen++;
        if (baud) baud_seen++;
        if (cmp_en) begin
            int mode;
            mode = (m_upper ? 2 : 0) + (sm1 ? 1 : 0);
            chk("R2 step register", phase_rd, m_step);
            chk("R3 mode register", mode_rd, {5'd0, m_irqen, m_rate, m_fedet});
            chk(m_fedet ? "R10 ctl bit7 error flag" : "R9 ctl bit7 mode bit", ctl7_rd,
                m_fedet ? m_fe : m_upper);
            chk("R4 baud pulse", baud, m_baud);
            chk(mode == 2 ? "R7 fixed-ratio tick" : (mode == 0 ? "R8 sync quiet tick"
                : "R6 async tick"), tick, m_tick);
            chk("R12 interrupt", irq, m_irq);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_step(input logic [15:0] v);
        @(negedge clk); phase_we = 1'b1; phase_wdata = v;
        @(negedge clk); phase_we = 1'b0;
    endtask

    task automatic put_mode(input logic [7:0] v);
        @(negedge clk); mode_we = 1'b1; mode_wdata = v;
        @(negedge clk); mode_we = 1'b0;
    endtask

    task automatic put_ctl7(input logic v);
        @(negedge clk); ctl7_we = 1'b1; ctl7_wdata = v;
        @(negedge clk); ctl7_we = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual expired expected finished");
        summary();
        $finish;
    end

    initial begin
        cyc(3);
        // R1 reset values at the ports
        chk("R1 reset step", phase_rd, 0);
        chk("R1 reset mode", mode_rd, 0);
        chk("R1 reset ctl7", ctl7_rd, 0);
        chk("R1 reset outputs", {baud, tick, irq}, 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        cyc(2);

        // R8: mode 0 with pulses running
        put_step(16'h1000);
        tick_seen = 0;
        cyc(200);
        chk("R8 ticks in sync mode", tick_seen, 0);

        // R6: mode 1, fast then slow
        sm1 = 1'b1;
        put_mode(8'h02);
        cyc(1200);
        put_step(16'hFFFF);
        put_mode(8'h00);
        cyc(2000);

        // R7: mode 2 fast and slow
        sm1 = 1'b0;
        put_ctl7(1'b1);
        put_mode(8'h02);
        tick_seen = 0;
        cyc(320);
        chk("R7 fast ticks in 320 clocks", tick_seen, 10);
        put_mode(8'h00);
        cyc(400);

        // R6: mode 3 with half-rate step
        sm1 = 1'b1;
        put_step(16'h8000);
        put_mode(8'h02);
        cyc(800);

        // R5: zero step stops everything
        put_step(16'h0000);
        cyc(4);
        tick_seen = 0; baud_seen = 0;
        cyc(600);
        chk("R5 ticks with zero step", tick_seen, 0);
        chk("R5 pulses with zero step", baud_seen, 0);

        // R10/R11: error flag behaviour
        sm1 = 1'b0;
        put_mode(8'h01);
        chk("R10 flag clear", ctl7_rd, 0);
        @(negedge clk); fe_set = 1'b1;
        @(negedge clk); fe_set = 1'b0;
        chk("R11 flag set by pulse", ctl7_rd, 1);
        cyc(20);
        chk("R11 flag holds", ctl7_rd, 1);
        @(negedge clk); fe_set = 1'b1; ctl7_we = 1'b1; ctl7_wdata = 1'b0;
        @(negedge clk); fe_set = 1'b0; ctl7_we = 1'b0;
        chk("R11 set wins over clear", ctl7_rd, 1);
        put_ctl7(1'b0);
        chk("R11 flag cleared by write 0", ctl7_rd, 0);
        put_ctl7(1'b1);
        chk("R10 flag written to 1", ctl7_rd, 1);
        put_mode(8'h00);
        chk("R10 upper mode bit untouched", ctl7_rd, 1);
        put_ctl7(1'b0);
        chk("R9 upper mode bit written 0", ctl7_rd, 0);
        put_mode(8'hF9);
        chk("R3 reserved bits read 0", mode_rd, 8'h01);

        // R12: interrupt gating
        put_mode(8'h00);
        @(negedge clk); ri = 1'b1; ti = 1'b1;
        @(negedge clk);
        chk("R12 disabled no request", irq, 0);
        ri = 1'b0; ti = 1'b0;
        put_mode(8'h04);
        @(negedge clk); ti = 1'b1;
        @(negedge clk); ti = 1'b0;
        chk("R12 request from ti", irq, 1);
        @(negedge clk);
        chk("R12 request drops", irq, 0);

        // mixed random stimulus against the model
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            phase_we   = ($urandom % 97) == 0;
            phase_wdata = 16'($urandom);
            mode_we    = ($urandom % 150) == 0;
            mode_wdata = 8'($urandom);
            ctl7_we    = ($urandom % 120) == 0;
            ctl7_wdata = 1'($urandom);
            fe_set     = ($urandom % 70) == 0;
            ri         = ($urandom % 9) == 0;
            ti         = ($urandom % 11) == 0;
            if (($urandom % 300) == 0) sm1 = ~sm1;
        end
        @(negedge clk);
        phase_we = 0; mode_we = 0; ctl7_we = 0; fe_set = 0; ri = 0; ti = 0;
        cyc(4);
        summary();
        $finish;
    end

endmodule